// File: doc/BRIEF.md
# UART Receive/Transmit Byte Packer with Address Filter

This block sits between the byte-level receive and transmit engines of a UART and a 32-bit host data word. On the receive side it takes each received character (eight data bits plus an optional ninth bit). In 9-bit mode with address detection on, it can drop every character whose ninth bit is clear. With packing on, it joins two accepted bytes into one 32-bit word, placing one byte in the low byte of each 16-bit half. A one-cycle re-align strobe forces the next accepted byte back into the lower half.

On the transmit side the host hands over a 32-bit word. With packing on, the block presents bits 7:0 and then bits 23:16 to the transmitter as two successive characters. With packing off, it presents a single character. The host is told when the next word may be loaded. Serial timing, baud generation, parity and the host bus are outside the block.

Top module: `uart_byte_packer`

## Requirements
- R1: After reset, rx_ready_o, rx_overrun_o, rx_irq_o and tx_byte_valid_o are 0 and tx_word_ready_o is 1. The packing position is the lower half, so the first byte accepted with packing on lands in bits 7:0.
- R2: With pack_en_i set, the first accepted byte goes to rx_word_o[7:0] and the second to rx_word_o[23:16]. Bits 31:24 and 15:8 are 0. rx_ready_o rises only in the cycle after the second byte is accepted.
- R3: With pack_en_i clear, each accepted byte gives rx_word_o = {24'h0, byte}, and rx_ready_o rises in the cycle after acceptance.
- R4: A cycle with rx_sync_i high sets the packing position to the lower half, and any half-built word is abandoned. A byte accepted in that same cycle goes to bits 7:0.
- R5: With rx_nine_en_i and rx_addr_en_i both set, a character with rx_char_i[8]=0 is discarded. It causes no ready, no interrupt and no change of packing position.
- R6: With either rx_nine_en_i or rx_addr_en_i clear, every character with rx_valid_i high is accepted, whatever rx_char_i[8] is.
- R7: rx_ninth_o[0] carries the ninth bit of the byte in bits 7:0 and rx_ninth_o[1] that of the byte in bits 23:16. Both are 0 when rx_nine_en_i is clear. In unpacked mode rx_ninth_o[1] is 0.
- R8: If a word completes while rx_ready_o is high and rx_read_i is low, rx_overrun_o is set and rx_word_o keeps the older word. A cycle with rx_read_i high clears rx_ready_o and rx_overrun_o, unless a new word completes in that same cycle, in which case that word is loaded.
- R9: rx_irq_o is high for exactly the one cycle after each word is loaded into rx_word_o.
- R10: With pack_en_i set at load, tx_byte_o[7:0] shows tx_word_i[7:0] and then tx_word_i[23:16]. Each byte is held until tx_byte_take_i. tx_word_ready_o returns to 1 only in the cycle after the second byte is taken.
- R11: With pack_en_i clear at load, only tx_word_i[7:0] is presented, and tx_word_ready_o returns in the cycle after it is taken.
- R12: tx_byte_o[8] equals tx_ninth_i[0] for the first byte and tx_ninth_i[1] for the second when tx_nine_en_i was set at load. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pack_en_i | input | 1 | Packing enable for both directions |
| rx_sync_i | input | 1 | One-cycle re-align strobe for receive packing |
| rx_nine_en_i | input | 1 | Receive 9-bit mode |
| rx_addr_en_i | input | 1 | Address-only filter (active in 9-bit receive mode) |
| tx_nine_en_i | input | 1 | Transmit 9-bit mode |
| rx_valid_i | input | 1 | Received character strobe |
| rx_char_i | input | 9 | Received character, bit 8 = ninth bit |
| rx_read_i | input | 1 | Host consumes rx_word_o |
| rx_word_o | output | 32 | Receive word |
| rx_ninth_o | output | 2 | Ninth bits of lower/upper byte |
| rx_ready_o | output | 1 | Receive word is waiting |
| rx_overrun_o | output | 1 | A word was lost while one was waiting |
| rx_irq_o | output | 1 | One-cycle pulse per loaded word |
| tx_load_i | input | 1 | Host loads tx_word_i |
| tx_word_i | input | 32 | Transmit word |
| tx_ninth_i | input | 2 | Ninth bits for first/second byte |
| tx_word_ready_o | output | 1 | Next transmit word may be loaded |
| tx_byte_o | output | 9 | Character to transmitter, bit 8 = ninth bit |
| tx_byte_valid_o | output | 1 | tx_byte_o is valid |
| tx_byte_take_i | input | 1 | Transmitter accepts tx_byte_o |

## Verification
The hardest states to reach are those where the packing position and the receive register are both already committed. Examples are a re-align strobe arriving after the first half of a word, a filtered character arriving between the two halves, and a second word completing while the first is still unread. The stimulus reaches them with deliberate sequences. It stops a pair halfway, then pulses the strobe, or inserts characters with the ninth bit clear, or withholds the host read across two completions. Only after that does it check the assembled word, the ninth-bit pair and the overrun flag.

// File: rtl/uart_pack_pkg.sv
package uart_pack_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 32;
  localparam int HALF_W = WORD_W / 2;
  localparam int CHAR_W = BYTE_W + 1;

  typedef struct packed {
    logic              ninth;
    logic [BYTE_W-1:0] data;
  } uart_char_t;
endpackage

// File: rtl/uart_rx_filter.sv
module uart_rx_filter
  import uart_pack_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       nine_en_i,
  input  logic       addr_en_i,
  input  logic       valid_i,
  input  uart_char_t char_i,
  output logic       accept_o,
  output uart_char_t char_o
);
  logic addr_mode;
  assign addr_mode = nine_en_i && addr_en_i;
  assign accept_o  = valid_i && (!addr_mode || char_i.ninth);
  assign char_o.data  = char_i.data;
  assign char_o.ninth = nine_en_i & char_i.ninth;

  p_drop_data_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && nine_en_i && addr_en_i && !char_i.ninth) |-> !accept_o);
  p_pass_all_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !(nine_en_i && addr_en_i)) |-> accept_o);
  p_ninth_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !nine_en_i |-> !char_o.ninth);
endmodule

// File: rtl/uart_rx_packer.sv
module uart_rx_packer
  import uart_pack_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pack_en_i,
  input  logic              sync_i,
  input  logic              accept_i,
  input  uart_char_t        char_i,
  input  logic              read_i,
  output logic [WORD_W-1:0] word_o,
  output logic [1:0]        ninth_o,
  output logic              ready_o,
  output logic              overrun_o,
  output logic              irq_o
);
  localparam int PAD_W = HALF_W - BYTE_W;

  logic              upper_q;
  logic [BYTE_W-1:0] lo_q;
  logic              lo_ninth_q;
  logic [WORD_W-1:0] word_q;
  logic [1:0]        ninth_q;
  logic              ready_q, overrun_q, irq_q;

  logic              to_upper, complete;
  logic [WORD_W-1:0] new_word;
  logic [1:0]        new_ninth;

  // sync strobe overrides a pending upper position
  assign to_upper = pack_en_i && upper_q && !sync_i;
  assign complete = accept_i && (!pack_en_i || to_upper);

  always_comb begin
    if (pack_en_i) begin
      new_word  = {{PAD_W{1'b0}}, char_i.data, {PAD_W{1'b0}}, lo_q};
      new_ninth = {char_i.ninth, lo_ninth_q};
    end else begin
      new_word  = {{(WORD_W-BYTE_W){1'b0}}, char_i.data};
      new_ninth = {1'b0, char_i.ninth};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      upper_q    <= 1'b0;
      lo_q       <= '0;
      lo_ninth_q <= 1'b0;
    end else if (!pack_en_i) begin
      upper_q <= 1'b0;
    end else if (accept_i) begin
      upper_q <= !to_upper;
      if (!to_upper) begin
        lo_q       <= char_i.data;
        lo_ninth_q <= char_i.ninth;
      end
    end else if (sync_i) begin
      upper_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q    <= '0;
      ninth_q   <= '0;
      ready_q   <= 1'b0;
      overrun_q <= 1'b0;
      irq_q     <= 1'b0;
    end else if (complete && (!ready_q || read_i)) begin
      word_q    <= new_word;
      ninth_q   <= new_ninth;
      ready_q   <= 1'b1;
      overrun_q <= 1'b0;
      irq_q     <= 1'b1;
    end else begin
      irq_q <= 1'b0;
      if (read_i) begin
        ready_q   <= 1'b0;
        overrun_q <= 1'b0;
      end else if (complete) begin
        overrun_q <= 1'b1;
      end
    end
  end

  assign word_o    = word_q;
  assign ninth_o   = ninth_q;
  assign ready_o   = ready_q;
  assign overrun_o = overrun_q;
  assign irq_o     = irq_q;

  p_pad_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_q |-> (word_q[WORD_W-1:HALF_W+BYTE_W] == '0 && word_q[HALF_W-1:BYTE_W] == '0));
  p_keep_old_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_q && !read_i && complete) |=> (overrun_q && $stable(word_q)));
  p_irq_loaded_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> ready_q);
  p_first_half_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_i && pack_en_i && !to_upper && !read_i) |=> !irq_q);
endmodule

// File: rtl/uart_tx_splitter.sv
module uart_tx_splitter
  import uart_pack_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pack_en_i,
  input  logic              nine_en_i,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [1:0]        ninth_i,
  input  logic              take_i,
  output logic              word_ready_o,
  output uart_char_t        byte_o,
  output logic              byte_valid_o
);
  logic              busy_q, hi_q, two_q, nine_q;
  logic [WORD_W-1:0] word_q;
  logic [1:0]        ninth_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      hi_q    <= 1'b0;
      two_q   <= 1'b0;
      nine_q  <= 1'b0;
      word_q  <= '0;
      ninth_q <= '0;
    end else if (!busy_q) begin
      if (load_i) begin
        busy_q  <= 1'b1;
        hi_q    <= 1'b0;
        two_q   <= pack_en_i;
        nine_q  <= nine_en_i;
        word_q  <= word_i;
        ninth_q <= ninth_i;
      end
    end else if (take_i) begin
      if (two_q && !hi_q) hi_q <= 1'b1;
      else                busy_q <= 1'b0;
    end
  end

  assign byte_o.data  = hi_q ? word_q[HALF_W+BYTE_W-1:HALF_W] : word_q[BYTE_W-1:0];
  assign byte_o.ninth = nine_q & (hi_q ? ninth_q[1] : ninth_q[0]);
  assign byte_valid_o = busy_q;
  assign word_ready_o = !busy_q;

  p_busy_blocks_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_o |-> !word_ready_o);
  p_hold_byte_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !take_i) |=> (busy_q && $stable(byte_o)));
  p_single_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !two_q && take_i) |=> !busy_q);
endmodule

// File: rtl/uart_byte_packer.sv
module uart_byte_packer
  import uart_pack_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        pack_en_i,
  input  logic        rx_sync_i,
  input  logic        rx_nine_en_i,
  input  logic        rx_addr_en_i,
  input  logic        tx_nine_en_i,
  input  logic        rx_valid_i,
  input  logic [8:0]  rx_char_i,
  input  logic        rx_read_i,
  output logic [31:0] rx_word_o,
  output logic [1:0]  rx_ninth_o,
  output logic        rx_ready_o,
  output logic        rx_overrun_o,
  output logic        rx_irq_o,
  input  logic        tx_load_i,
  input  logic [31:0] tx_word_i,
  input  logic [1:0]  tx_ninth_i,
  output logic        tx_word_ready_o,
  output logic [8:0]  tx_byte_o,
  output logic        tx_byte_valid_o,
  input  logic        tx_byte_take_i
);
  logic       acc;
  uart_char_t rx_in, rx_kept, tx_ch;

  assign rx_in = rx_char_i;

  uart_rx_filter u_filter (
    .clk_i, .rst_ni,
    .nine_en_i(rx_nine_en_i), .addr_en_i(rx_addr_en_i),
    .valid_i(rx_valid_i), .char_i(rx_in),
    .accept_o(acc), .char_o(rx_kept)
  );

  uart_rx_packer u_pack (
    .clk_i, .rst_ni,
    .pack_en_i, .sync_i(rx_sync_i), .accept_i(acc), .char_i(rx_kept),
    .read_i(rx_read_i), .word_o(rx_word_o), .ninth_o(rx_ninth_o),
    .ready_o(rx_ready_o), .overrun_o(rx_overrun_o), .irq_o(rx_irq_o)
  );

  uart_tx_splitter u_split (
    .clk_i, .rst_ni,
    .pack_en_i, .nine_en_i(tx_nine_en_i), .load_i(tx_load_i),
    .word_i(tx_word_i), .ninth_i(tx_ninth_i), .take_i(tx_byte_take_i),
    .word_ready_o(tx_word_ready_o), .byte_o(tx_ch), .byte_valid_o(tx_byte_valid_o)
  );

  assign tx_byte_o = tx_ch;
endmodule

// File: tb/tb_uart_byte_packer.sv
`timescale 1ns/1ps
module tb_uart_byte_packer;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic pack_en = 0, rx_sync = 0, rx_nine = 0, rx_addr = 0, tx_nine = 0;
  logic rx_valid = 0, rx_read = 0, tx_load = 0, tx_take = 0;
  logic [8:0]  rx_char = '0;
  logic [31:0] tx_word = '0;
  logic [1:0]  tx_ninth = '0;
  logic [31:0] rx_word;
  logic [1:0]  rx_ninth;
  logic rx_ready, rx_ovr, rx_irq, tx_rdy, tx_vld;
  logic [8:0] tx_byte;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  uart_byte_packer dut (
    .clk_i(clk), .rst_ni, .pack_en_i(pack_en), .rx_sync_i(rx_sync),
    .rx_nine_en_i(rx_nine), .rx_addr_en_i(rx_addr), .tx_nine_en_i(tx_nine),
    .rx_valid_i(rx_valid), .rx_char_i(rx_char), .rx_read_i(rx_read),
    .rx_word_o(rx_word), .rx_ninth_o(rx_ninth), .rx_ready_o(rx_ready),
    .rx_overrun_o(rx_ovr), .rx_irq_o(rx_irq), .tx_load_i(tx_load),
    .tx_word_i(tx_word), .tx_ninth_i(tx_ninth), .tx_word_ready_o(tx_rdy),
    .tx_byte_o(tx_byte), .tx_byte_valid_o(tx_vld), .tx_byte_take_i(tx_take)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rx_send(input logic [8:0] c);
    rx_char = c; rx_valid = 1;
    @(negedge clk);
    rx_valid = 0;
  endtask

  task automatic rx_take_word();
    rx_read = 1;
    @(negedge clk);
    rx_read = 0;
  endtask

  task automatic tx_step();
    tx_take = 1;
    @(negedge clk);
    tx_take = 0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ready", rx_ready, 0); chk("R1 ovr", rx_ovr, 0); chk("R1 irq", rx_irq, 0);
    chk("R1 txrdy", tx_rdy, 1);   chk("R1 txvld", tx_vld, 0);
    rst_ni = 1;
    @(negedge clk);

    // R3 R9 unpacked sweep over all byte values
    for (int v = 0; v < 256; v++) begin
      rx_send({1'b0, 8'(v)});
      chk("R3 word", rx_word, 32'(v));
      chk("R3 ready", rx_ready, 1);
      chk("R9 irq", rx_irq, 1);
      rx_take_word();
      chk("R9 irq one cycle", rx_irq, 0);
      chk("R8 read clears", rx_ready, 0);
    end

    // R1 first packed byte lands low; R2 pairs
    pack_en = 1;
    for (int a = 0; a < 64; a++) begin
      logic [7:0] b0, b1;
      b0 = 8'(a * 37 + 5); b1 = 8'(255 - a * 11);
      rx_send({1'b0, b0});
      chk("R2 no ready after first", rx_ready, 0);
      chk("R2 no irq after first", rx_irq, 0);
      rx_send({1'b0, b1});
      chk("R2 word", rx_word, {8'h0, b1, 8'h0, b0});
      chk("R2 ready", rx_ready, 1);
      rx_take_word();
    end

    // R4 re-align after half word
    rx_send(9'h011);
    rx_sync = 1; @(negedge clk); rx_sync = 0;
    rx_send(9'h022); rx_send(9'h033);
    chk("R4 realign", rx_word, 32'h0033_0022);
    rx_take_word();
    // R4 sync coincident with byte
    rx_send(9'h044);
    rx_sync = 1; rx_send(9'h055); rx_sync = 0;
    chk("R4 same-cycle no word", rx_ready, 0);
    rx_send(9'h066);
    chk("R4 same-cycle", rx_word, 32'h0066_0055);
    rx_take_word();

    // R5 R7 address filter
    rx_nine = 1; rx_addr = 1;
    rx_send(9'h055);
    chk("R5 drop ready", rx_ready, 0); chk("R5 drop irq", rx_irq, 0);
    rx_send(9'h1AA); rx_send(9'h0BB); rx_send(9'h1CC);
    chk("R5 word", rx_word, 32'h00CC_00AA);
    chk("R7 ninth both", {30'h0, rx_ninth}, 32'h3);
    rx_take_word();

    // R6 R7 nine on, filter off
    rx_addr = 0;
    rx_send(9'h012); rx_send(9'h134);
    chk("R6 word", rx_word, 32'h0034_0012);
    chk("R7 ninth hi", {30'h0, rx_ninth}, 32'h2);
    rx_take_word();
    // R6 R7 filter on, nine off
    rx_nine = 0; rx_addr = 1; pack_en = 0;
    rx_send(9'h177);
    chk("R6 nine off accepted", rx_word, 32'h77);
    chk("R7 ninth zero", {30'h0, rx_ninth}, 32'h0);
    rx_take_word();
    rx_send(9'h078);
    chk("R6 nine off bit8 clear", rx_word, 32'h78);
    rx_take_word();

    // R8 overrun
    rx_send(9'h001); rx_send(9'h002);
    chk("R8 kept", rx_word, 32'h1); chk("R8 ovr", rx_ovr, 1);
    rx_take_word();
    chk("R8 ovr clear", rx_ovr, 0); chk("R8 ready clear", rx_ready, 0);
    rx_send(9'h003);
    rx_read = 1; rx_send(9'h004); rx_read = 0;
    chk("R8 read+new", rx_word, 32'h4); chk("R8 read+new rdy", rx_ready, 1);
    chk("R8 read+new ovr", rx_ovr, 0);
    rx_take_word();

    // R10 R12 packed transmit sweep
    pack_en = 1;
    for (int k = 0; k < 16; k++) begin
      logic [31:0] w;
      w = 32'h1357_9BDF * (k + 1);
      tx_nine = k[0]; tx_ninth = 2'(k >> 1);
      tx_word = w; tx_load = 1; @(negedge clk); tx_load = 0;
      chk("R10 busy", tx_rdy, 0); chk("R10 valid", tx_vld, 1);
      chk("R10 first", tx_byte[7:0], w[7:0]);
      chk("R12 first ninth", tx_byte[8], k[0] & tx_ninth[0]);
      @(negedge clk);
      chk("R10 hold", tx_byte[7:0], w[7:0]);
      tx_step();
      chk("R10 second", tx_byte[7:0], w[23:16]);
      chk("R12 second ninth", tx_byte[8], k[0] & tx_ninth[1]);
      chk("R10 still busy", tx_rdy, 0);
      tx_step();
      chk("R10 ready", tx_rdy, 1); chk("R10 idle", tx_vld, 0);
    end

    // R11 unpacked transmit
    pack_en = 0; tx_nine = 0;
    tx_word = 32'h00EE_00A5; tx_load = 1; @(negedge clk); tx_load = 0;
    chk("R11 byte", tx_byte, 9'h0A5);
    tx_step();
    chk("R11 ready", tx_rdy, 1); chk("R11 idle", tx_vld, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule